// File: doc/BRIEF.md
# Time-Multiplexed Serial ADC Frame Receiver

This block takes the serial output of an external multi-channel converter that puts every channel's result on one data pin, one slot after another. The converter supplies its own bit clock, which keeps toggling between frames. It also supplies a frame strobe that is high for the first bit of each frame. The receiver brings all three lines into the system clock domain. It shifts in a frame of four 32-bit slots and then presents the four channel words side by side.

Each complete frame raises a valid flag, which stays up until the consumer accepts the words with a ready pulse. If another frame completes before that acceptance, the newer words replace the older ones and an overrun flag marks the loss. Bits that arrive after a frame is full are ignored until the next strobe. A strobe that comes in the middle of a frame throws away the partial frame and starts again.

Top module: `tdm_adc_rx`

## Requirements
- R1: While reset is asserted, and afterwards until the first frame completes, `out_valid` and `overrun` are 0 and `out_words` is all zeros.
- R2: Serial data is sampled on each rising edge of the bit clock, seen after synchronization into `clk`, with the most significant bit of each slot first. The bit sampled on the rising edge where `frame_strobe` is high is bit 31 of slot 0. The system clock must run at least 4 times faster than the bit clock.
- R3: Slot k (k = 0..3, slot 0 received first) appears at `out_words[32*k+31 : 32*k]`.
- R4: When the 128th bit of a frame is sampled, `out_valid` goes to 1. It stays at 1, with `out_words` unchanged, until a cycle with `out_ready` high accepts the words. After that cycle `out_valid` is 0.
- R5: Bits sampled after the 128th bit of a frame and before the next strobe do not change `out_words` and do not raise `out_valid`.
- R6: A strobe seen partway through a frame discards the bits gathered so far and starts a new frame at slot 0, bit 31.
- R7: If a frame completes while `out_valid` is 1 and `out_ready` is 0, the new words replace the held words and `overrun` becomes 1. `overrun` returns to 0 when the words are accepted, and it is never 1 while `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| bclk | input | 1 | Converter bit clock, asynchronous, free-running |
| frame_strobe | input | 1 | Data-ready frame strobe, high for the first bit of a frame |
| sdata | input | 1 | Serial slot data |
| out_ready | input | 1 | Consumer accepts the held words |
| out_valid | output | 1 | A complete frame is held |
| out_words | output | 128 | Four channel words, slot k at bits 32k+31..32k |
| overrun | output | 1 | The held frame replaced one that was never accepted |

## Verification
The bench uses random frames and three directed frames. The directed frames are all ones, one word per slot whose bits mark only the ends, and slot indices in the high bytes. Any bit reversal, slot swap or off-by-one in the shift register shows up as a wrong word in these frames. Two frames sent back to back without acceptance separate correct overrun handling from silently dropping the newer frame. A burst of trailing bits after a full frame shows whether the capture stops at 128 bits. A restarted frame cut off after 50 bits shows whether the strobe really clears the bit and slot position.

// File: rtl/tdm_adc_rx.sv
module tdm_adc_rx #(
  parameter int SLOTS       = 4,
  parameter int SLOT_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bclk,
  input  logic                    frame_strobe,
  input  logic                    sdata,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic [SLOTS*SLOT_W-1:0] out_words,
  output logic                    overrun
);
  localparam int TOTAL = SLOTS * SLOT_W;
  localparam int CW    = $clog2(TOTAL + 1);

  logic [SYNC_STAGES-1:0] bclk_sr, strb_sr, data_sr;
  logic                   bclk_d;
  logic                   active;
  logic [CW-1:0]          cnt;
  logic [TOTAL-1:0]       shreg;
  logic [TOTAL-1:0]       next_frame, next_words;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_sr <= '0;
      strb_sr <= '0;
      data_sr <= '0;
      bclk_d  <= 1'b0;
    end else begin
      bclk_sr <= {bclk_sr[SYNC_STAGES-2:0], bclk};
      strb_sr <= {strb_sr[SYNC_STAGES-2:0], frame_strobe};
      data_sr <= {data_sr[SYNC_STAGES-2:0], sdata};
      bclk_d  <= bclk_sr[SYNC_STAGES-1];
    end
  end

  wire bclk_q     = bclk_sr[SYNC_STAGES-1];
  wire strb_q     = strb_sr[SYNC_STAGES-1];
  wire data_q     = data_sr[SYNC_STAGES-1];
  wire rise       = bclk_q & ~bclk_d;
  wire start      = rise & strb_q;
  wire take       = rise & (start | active);
  wire frame_done = take & ~start & (cnt == CW'(TOTAL - 1));

  assign next_frame = {shreg[TOTAL-2:0], data_q};

  for (genvar k = 0; k < SLOTS; k++) begin : g_map
    assign next_words[k*SLOT_W +: SLOT_W] = next_frame[(SLOTS-1-k)*SLOT_W +: SLOT_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      shreg  <= '0;
    end else begin
      if (take) shreg <= next_frame;
      if (start) begin
        active <= 1'b1;
        cnt    <= CW'(1);
      end else if (frame_done) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (take) begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_words <= '0;
      overrun   <= 1'b0;
    end else if (frame_done) begin
      out_valid <= 1'b1;
      out_words <= next_words;
      overrun   <= out_valid & ~out_ready;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
      overrun   <= 1'b0;
    end
  end
endmodule

module tdm_adc_rx_chk #(
  parameter int W = 128
) (
  input logic         clk,
  input logic         rst_n,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_words,
  input logic         overrun,
  input logic         frame_done
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !overrun && out_words == '0));

  assert_hold_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  assert_hold_words_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !frame_done |=> $stable(out_words));

  assert_no_double_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  assert_overrun_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && frame_done |=> overrun);

  assert_overrun_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !overrun);
endmodule

bind tdm_adc_rx tdm_adc_rx_chk #(.W(SLOTS*SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_words(out_words), .overrun(overrun), .frame_done(frame_done)
);

// File: tb/tb_tdm_adc_rx.sv
module tb_tdm_adc_rx;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bclk = 1'b0, frame_strobe = 1'b0, sdata = 1'b0, out_ready = 1'b0;
  logic out_valid, overrun;
  logic [127:0] out_words;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_adc_rx dut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .frame_strobe(frame_strobe),
    .sdata(sdata), .out_ready(out_ready), .out_valid(out_valid),
    .out_words(out_words), .overrun(overrun)
  );

  function automatic logic [127:0] pack(input logic [31:0] s0, s1, s2, s3);
    return {s3, s2, s1, s0};
  endfunction

  function automatic logic stream_bit(input logic [127:0] w, input int i);
    return w[(i / 32) * 32 + 31 - (i % 32)];
  endfunction

  task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic send_bit(input logic b, input logic s);
    @(negedge clk);
    bclk = 1'b0; sdata = b; frame_strobe = s;
    repeat (HALF_BIT - 1) @(negedge clk);
    @(negedge clk);
    bclk = 1'b1;
    repeat (HALF_BIT) @(negedge clk);
  endtask

  task automatic send_bits(input logic [127:0] w, input int n);
    for (int i = 0; i < n; i++) send_bit(stream_bit(w, i), i == 0);
  endtask

  task automatic accept();
    @(negedge clk); out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
  endtask

  task automatic frame_and_check(input logic [127:0] w, input string tag);
    send_bits(w, 128);
    send_bit(1'b0, 1'b0);
    check({tag, " R4 valid"}, {127'd0, out_valid}, 128'd1);
    check({tag, " R2 R3 words"}, out_words, w);
    check({tag, " R7 no overrun"}, {127'd0, overrun}, 128'd0);
    repeat (6) @(negedge clk);
    check({tag, " R4 held"}, out_words, w);
    accept();
    check({tag, " R4 cleared"}, {127'd0, out_valid}, 128'd0);
  endtask

  initial begin
    logic [127:0] a, b, c;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {127'd0, out_valid}, 128'd0);
    check("R1 overrun in reset", {127'd0, overrun}, 128'd0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check("R1 words after reset", out_words, 128'd0);
    check("R1 valid after reset", {127'd0, out_valid}, 128'd0);

    frame_and_check({128{1'b1}}, "ones");
    frame_and_check(pack(32'h8000_0001, 32'h4000_0002, 32'h2000_0004, 32'h1000_0008), "ends");
    frame_and_check(pack(32'h00AA_55FF, 32'h01CC_3300, 32'h02F0_0F0F, 32'h0312_3456), "index");
    for (int r = 0; r < 6; r++)
      frame_and_check({$urandom, $urandom, $urandom, $urandom}, "random");

    a = {$urandom, $urandom, $urandom, $urandom};
    b = {$urandom, $urandom, $urandom, $urandom};
    send_bits(a, 128);
    send_bits(b, 128);
    send_bit(1'b0, 1'b0);
    check("R7 overrun set", {127'd0, overrun}, 128'd1);
    check("R7 newer words kept", out_words, b);
    accept();
    check("R7 overrun cleared", {127'd0, overrun}, 128'd0);
    check("R7 valid cleared", {127'd0, out_valid}, 128'd0);

    c = {$urandom, $urandom, $urandom, $urandom};
    frame_and_check(c, "pre-tail");
    for (int i = 0; i < 60; i++) send_bit(1'($urandom), 1'b0);
    check("R5 tail no valid", {127'd0, out_valid}, 128'd0);
    check("R5 tail words kept", out_words, c);

    a = {$urandom, $urandom, $urandom, $urandom};
    b = {$urandom, $urandom, $urandom, $urandom};
    send_bits(a, 50);
    check("R6 partial no valid", {127'd0, out_valid}, 128'd0);
    send_bits(b, 128);
    send_bit(1'b0, 1'b0);
    check("R6 restart words", out_words, b);
    check("R6 single completion", {127'd0, overrun}, 128'd0);
    accept();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule